// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block arbitrates eight interrupt levels for a small processor core. Each level owns one bit in a waiting-request register and one bit in an in-service register. Incoming requests are merged into the waiting register only in cycles the core marks as non-I/O instruction cycles. The controller asks the core for service only when the best waiting level outranks everything already in service. The core's global enable flag can hold off new service without losing the record of what arrived.

The core answers a raised request with an acknowledge strobe. In that cycle the controller marks the presented level as in service, and the core uses the presented level index as the target of its short call. A return-from-interrupt strobe retires the most important level in service, clearing it from both registers. The level it had preempted is then the top of the in-service set again. A request that arrives while its own level is still waiting or in service merges into the bit already set, so it is lost as a separate event.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset is released, `pend_o`, `act_o`, `irq_o` and `vec_o` are all zero.
- R2: In a cycle with `sample_i` high, the `req_i` bits are ORed into `pend_o` (bit n = level n), visible after the next rising edge. With `sample_i` low, `req_i` has no effect.
- R3: `irq_o` is high exactly when `int_en_i` is high and some level n has `pend_o[n]`=1, `act_o[n]`=0 and n greater than the highest set bit of `act_o` (any n when `act_o` is zero).
- R4: `vec_o` is the binary index of the highest level meeting the R3 condition, and 0 when none does.
- R5: `ack_i` high with `irq_o` high and `rti_i` low sets `act_o[vec_o]` after the edge. `ack_i` under any other condition changes nothing.
- R6: `rti_i` clears the highest set bit of `act_o`, and the same bit of `pend_o`, after the edge. With `act_o` zero it changes nothing. A bit of `act_o` is never set without the same bit of `pend_o`.
- R7: With `int_en_i` low, `irq_o` stays low while requests are still recorded in `pend_o`. Service of them is raised once `int_en_i` returns high.
- R8: A request for a level whose `pend_o` bit is already set leaves no trace. After that level's single return, its bit is clear.
- R9: Level 7 ranks highest and level 0 lowest. A level equal to or below the highest in-service level never raises `irq_o`.
- R10: A request sampled in the same cycle as the return that retires its level is recorded, so that bit of `pend_o` is set after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low master reset |
| req_i | input | 8 | Request lines, one per level |
| sample_i | input | 1 | Non-I/O instruction cycle qualifier for request capture |
| int_en_i | input | 1 | Core's global interrupt enable flag |
| ack_i | input | 1 | Core accepts the presented interrupt |
| rti_i | input | 1 | Core executes a return from interrupt |
| irq_o | output | 1 | Service request to the core |
| vec_o | output | 3 | Index of the level to be called |
| pend_o | output | 8 | Waiting-request register |
| act_o | output | 8 | In-service register |

## Verification
The first directed pattern raises levels 2, then 5, then 3, then 7. This separates strict preemption from equal-or-lower requests, which must only wait. The returns that follow show whether the retired level is the top one and whether the preempted level comes back as in service. Separate patterns toggle the enable flag with requests arriving, repeat a request on a busy level, and land a request on the very cycle its level retires; these tell deferral apart from loss. A long random mix of requests, sampling gaps, acknowledges and returns is then compared every cycle against a behavioural model. This catches ordering faults that the directed cases do not reach.

// File: rtl/nirq_pkg.sv
package nirq_pkg;

  // Index of the highest set bit, or -1 when the vector is empty.
  function automatic int top_bit(input logic [31:0] v);
    int r;
    r = -1;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

  // Mask of all bit positions strictly above idx (idx = -1 gives all ones).
  function automatic logic [31:0] above_mask(input int idx);
    logic [32:0] low;
    low = (33'd1 << (idx + 1)) - 33'd1;
    return ~low[31:0];
  endfunction

  // One-hot vector for idx, zero when idx is negative.
  function automatic logic [31:0] one_hot(input int idx);
    return (idx >= 0) ? (32'd1 << idx) : 32'd0;
  endfunction

endpackage

// File: rtl/nirq_pend_reg.sv
module nirq_pend_reg #(
  parameter int NUM_LEVELS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sample_i,
  input  logic [NUM_LEVELS-1:0] req_i,
  input  logic [NUM_LEVELS-1:0] clr_i,
  output logic [NUM_LEVELS-1:0] pend_o
);

  logic [NUM_LEVELS-1:0] pend_q;
  logic [NUM_LEVELS-1:0] capture;

  // clear first, then merge new requests, so a same-cycle request survives
  assign capture = sample_i ? req_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_i) | capture;
  end

  assign pend_o = pend_q;

  assert_hold_without_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_i && clr_i == '0) |=> $stable(pend_q));

  assert_bits_only_drop_on_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i == '0) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

endmodule

// File: rtl/nirq_act_reg.sv
module nirq_act_reg
  import nirq_pkg::*;
#(
  parameter int NUM_LEVELS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LEVELS-1:0] set_i,
  input  logic                  rti_i,
  output logic [NUM_LEVELS-1:0] act_o,
  output logic [NUM_LEVELS-1:0] retire_o
);

  logic [NUM_LEVELS-1:0] act_q;
  int                    top_act;

  assign top_act  = top_bit(32'(act_q));
  assign retire_o = rti_i ? NUM_LEVELS'(one_hot(top_act)) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     act_q <= '0;
    else if (rti_i) act_q <= act_q & ~retire_o;
    else            act_q <= act_q | set_i;
  end

  assign act_o = act_q;

  assert_set_single_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_i));

  assert_rti_retires_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rti_i && act_q != '0) |=> ($countones(act_q) == $countones($past(act_q)) - 1));

  assert_rti_empty_noop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rti_i && act_q == '0) |=> (act_q == '0));

endmodule

// File: rtl/nirq_arbiter.sv
module nirq_arbiter
  import nirq_pkg::*;
#(
  parameter int NUM_LEVELS = 8,
  parameter int IDX_W      = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LEVELS-1:0] pend_i,
  input  logic [NUM_LEVELS-1:0] act_i,
  input  logic                  en_i,
  output logic                  irq_o,
  output logic [IDX_W-1:0]      idx_o,
  output logic [NUM_LEVELS-1:0] grant_o
);

  int                    top_act;
  int                    sel;
  logic [NUM_LEVELS-1:0] eligible;

  assign top_act  = top_bit(32'(act_i));
  assign eligible = pend_i & ~act_i & NUM_LEVELS'(above_mask(top_act));
  assign sel      = top_bit(32'(eligible));

  assign irq_o   = en_i && (sel >= 0);
  assign idx_o   = (sel >= 0) ? IDX_W'(sel) : '0;
  assign grant_o = NUM_LEVELS'(one_hot(sel));

  assert_vec_is_waiting_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pend_i[idx_o] && !act_i[idx_o]));

  assert_preempt_strict_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((act_i >> idx_o) == '0));

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
  parameter int NUM_LEVELS = 8,
  localparam int IDX_W     = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LEVELS-1:0] req_i,
  input  logic                  sample_i,
  input  logic                  int_en_i,
  input  logic                  ack_i,
  input  logic                  rti_i,
  output logic                  irq_o,
  output logic [IDX_W-1:0]      vec_o,
  output logic [NUM_LEVELS-1:0] pend_o,
  output logic [NUM_LEVELS-1:0] act_o
);

  logic [NUM_LEVELS-1:0] pend_w;
  logic [NUM_LEVELS-1:0] act_w;
  logic [NUM_LEVELS-1:0] grant_w;
  logic [NUM_LEVELS-1:0] retire_w;
  logic [NUM_LEVELS-1:0] set_w;
  logic                  irq_w;
  logic [IDX_W-1:0]      idx_w;
  logic                  ack_fire;

  // a return in the same cycle wins over an acknowledge
  assign ack_fire = ack_i && irq_w && !rti_i;
  assign set_w    = ack_fire ? grant_w : '0;

  nirq_pend_reg #(.NUM_LEVELS(NUM_LEVELS)) i_pend (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .req_i(req_i),
    .clr_i(retire_w), .pend_o(pend_w)
  );

  nirq_act_reg #(.NUM_LEVELS(NUM_LEVELS)) i_act (
    .clk(clk), .rst_n(rst_n), .set_i(set_w), .rti_i(rti_i),
    .act_o(act_w), .retire_o(retire_w)
  );

  nirq_arbiter #(.NUM_LEVELS(NUM_LEVELS), .IDX_W(IDX_W)) i_arb (
    .clk(clk), .rst_n(rst_n), .pend_i(pend_w), .act_i(act_w), .en_i(int_en_i),
    .irq_o(irq_w), .idx_o(idx_w), .grant_o(grant_w)
  );

  assign irq_o  = irq_w;
  assign vec_o  = idx_w;
  assign pend_o = pend_w;
  assign act_o  = act_w;

  assert_gate_by_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en_i |-> !irq_o);

  assert_active_within_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((act_o & ~pend_o) == '0));

  assert_ack_marks_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> act_o[$past(vec_o)]);

endmodule

// File: tb/test_nest_irq_ctrl.sv
module test_nest_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] req = 0;
  logic       smp = 0, en = 0, ack = 0, rti = 0;
  logic       irq;
  logic [2:0] vec;
  logic [7:0] pend, act;

  int checks = 0;
  int fails  = 0;

  logic [7:0] m_pend = 0, m_act = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nest_irq_ctrl i_nest_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req), .sample_i(smp), .int_en_i(en),
    .ack_i(ack), .rti_i(rti), .irq_o(irq), .vec_o(vec), .pend_o(pend), .act_o(act)
  );

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  // behavioural reference: which level would be called now (-1 = none)
  function automatic int model_pick();
    int hi_act;
    hi_act = -1;
    for (int i = 7; i >= 0; i--) if (m_act[i] && hi_act < 0) hi_act = i;
    for (int i = 7; i > hi_act; i--) if (m_pend[i] && !m_act[i]) return i;
    return -1;
  endfunction

  task automatic compare(input string tag);
    int p;
    p = model_pick();
    chk(tag, "pend_o (R2)", pend, m_pend);
    chk(tag, "act_o (R6)", act, m_act);
    chk(tag, "irq_o (R3)", irq, (en && p >= 0) ? 1 : 0);
    chk(tag, "vec_o (R4)", vec, (p >= 0) ? p : 0);
  endtask

  // drive at negedge, compare before and after the edge
  task automatic step(input logic [7:0] rq, input logic s, input logic e,
                      input logic a, input logic r, input string tag);
    int p;
    req = rq; smp = s; en = e; ack = a; rti = r;
    #1;
    compare(tag);
    p = model_pick();
    @(posedge clk);
    if (r) begin
      for (int i = 7; i >= 0; i--) begin
        if (m_act[i]) begin
          m_act[i] = 1'b0; m_pend[i] = 1'b0;
          break;
        end
      end
    end else if (a && e && p >= 0) begin
      m_act[p] = 1'b1;
    end
    if (s) m_pend = m_pend | rq;
    @(negedge clk);
    req = 0; smp = 0; ack = 0; rti = 0;
    #1;
    compare(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1: everything clear after reset
    chk("R1", "pend_o", pend, 0);
    chk("R1", "act_o", act, 0);
    chk("R1", "irq_o", irq, 0);
    chk("R1", "vec_o", vec, 0);

    // R2: no capture without the qualifier, capture with it
    step(8'h04, 0, 1, 0, 0, "R2");
    chk("R2", "pend_o unsampled", pend, 8'h00);
    step(8'h04, 1, 1, 0, 0, "R2");
    chk("R2", "pend_o sampled", pend, 8'h04);
    chk("R4", "vec_o level2", vec, 2);

    // R5: acknowledge level 2, then preempt by 5, block 3, preempt by 7
    step(8'h00, 0, 1, 1, 0, "R5");
    chk("R5", "act_o", act, 8'h04);
    step(8'h20, 1, 1, 0, 0, "R9");
    chk("R9", "irq_o for 5", irq, 1);
    step(8'h00, 0, 1, 1, 0, "R5");
    step(8'h08, 1, 1, 0, 0, "R9");
    chk("R9", "irq_o for 3 under 5", irq, 0);
    step(8'h80, 1, 1, 0, 0, "R9");
    chk("R9", "vec_o for 7", vec, 7);
    step(8'h00, 0, 1, 1, 0, "R5");
    chk("R5", "act_o nested", act, 8'hA4);
    // R5: acknowledge with nothing to serve is ignored
    step(8'h00, 0, 1, 1, 0, "R5");
    chk("R5", "act_o idle ack", act, 8'hA4);
    // R6: returns unwind top first
    step(8'h00, 0, 1, 0, 1, "R6");
    chk("R6", "act_o after first return", act, 8'h24);
    step(8'h00, 0, 1, 0, 1, "R6");
    chk("R6", "act_o after second return", act, 8'h04);
    chk("R9", "level3 now callable", vec, 3);
    step(8'h00, 0, 1, 1, 1, "R5");
    chk("R5", "ack ignored with rti", act, 8'h00);
    step(8'h00, 0, 1, 1, 0, "R6");
    step(8'h00, 0, 1, 0, 1, "R6");
    step(8'h00, 0, 1, 0, 1, "R6");
    chk("R6", "empty return", act, 8'h00);

    // R7: disabled enable still logs, service deferred
    step(8'h02, 1, 0, 1, 0, "R7");
    chk("R7", "pend_o logged", pend, 8'h02);
    chk("R7", "irq_o held", irq, 0);
    chk("R7", "act_o untouched", act, 8'h00);
    step(8'h00, 0, 1, 0, 0, "R7");
    chk("R7", "irq_o resumes", irq, 1);
    step(8'h00, 0, 1, 1, 0, "R7");

    // R8: repeat request on a busy level is lost
    step(8'h02, 1, 1, 0, 0, "R8");
    step(8'h00, 0, 1, 0, 1, "R8");
    chk("R8", "pend_o after one return", pend, 8'h00);
    chk("R8", "irq_o", irq, 0);

    // R10: request arriving with its own retirement is kept
    step(8'h10, 1, 1, 0, 0, "R10");
    step(8'h00, 0, 1, 1, 0, "R10");
    step(8'h10, 1, 1, 0, 1, "R10");
    chk("R10", "pend_o", pend, 8'h10);
    chk("R10", "act_o", act, 8'h00);
    step(8'h00, 0, 1, 1, 0, "R10");
    step(8'h00, 0, 1, 0, 1, "R10");

    // random mix against the model (R3 R4 R5 R6)
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] rq;
      rq = (($urandom % 4) == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
      step(rq, ($urandom % 4) != 0, ($urandom % 5) != 0,
           ($urandom % 2) == 0, ($urandom % 7) == 0, "R3");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule